// File: doc/BRIEF.md
# Power-Save Mode Clock Controller

This block sequences the clocks of a small microcontroller through its standby modes. Software loads a control word holding a two-bit standby mode, a bit that stops the main oscillator, a choice between the two slow clocks (sub oscillator or ring oscillator), a bit that moves the CPU onto the main oscillator, a calibration-timer clock choice and a wake-event mask. A standby request then moves the block into one of four standby states. A wake event that the mask lets through brings it back to run.

The standby state that is actually entered depends on the clock the CPU is running on. The oscillator-stop bit acts differently in each mode. It decides whether the main oscillator runs during standby. It also decides which clock the CPU gets after wake-up. Whenever the main oscillator is enabled again, a down-counter times its start-up. The CPU can only be moved to that oscillator once the count has run out. Each change of the CPU clock source waits for a cycle in which the old clock and the new clock are both low. The analog oscillators are outside the block. Each one appears only as a sampled clock level, plus the enable that the block drives.

Top module: `pscTop`

## Requirements
- R1: After reset, pwrState is 0 (run), cpuSrc is 0 (ring oscillator), mainOscEn, oscStable, wtClkEn and calClkSel are 0, and cpuClkEn and periClkEn are 1. The oscillator-stop bit resets to 1, the slow-clock choice to 0 and the wake mask to all ones.
- R2: A standbyReq in run, while the CPU runs on the main oscillator, moves pwrState at the next edge as follows. Mode 00 gives 1 (idle), 01 gives 2 (stop), 10 gives 3 (watch) and 11 gives 4 (sub-watch).
- R3: If the CPU runs on a slow clock, modes 00 and 10 enter sub-watch (4) instead. Mode 01 still enters stop.
- R4: In sub-watch, mainOscEn is 0 whatever the oscillator-stop bit holds.
- R5: A wake from sub-watch with the oscillator-stop bit at 0 gives pwrState 5 (start-up wait) with mainOscEn at 1. The block returns to run only after the stabilization count has elapsed, and the CPU is then moved to the main oscillator (cpuSrc 2).
- R6: A wake from sub-watch with the oscillator-stop bit at 1 returns straight to run. mainOscEn stays 0 and the CPU stays on the selected slow clock (cpuSrc 1 for sub oscillator, 0 for ring).
- R7: In watch, mainOscEn equals the inverse of the oscillator-stop bit. After wake, the CPU ends on the main oscillator (cpuSrc 2) in both cases, through the start-up wait when the oscillator had been stopped.
- R8: oscStable rises exactly STAB_CYCLES clock edges after the edge that enables the main oscillator.
- R9: A request to run the CPU on the main oscillator is taken only while oscStable is 1. Otherwise cpuSrc does not change.
- R10: Writing the oscillator-stop bit as 1 forces wtClkEn to 0 at the write edge. While the CPU still runs on the main oscillator, that oscillator keeps running.
- R11: calClkSel follows the written calibration-clock bit: 0 selects the peripheral clock, 1 the main oscillator.
- R12: The clock gates follow the state. Run drives cpuClkEn=1 and periClkEn=1, idle drives cpuClkEn=0 and periClkEn=1, and stop drives both to 0.
- R13: Only wakeReq bits that are also set in the wake mask end a standby state. Masked bits leave pwrState unchanged.
- R14: cpuSrc changes only at an edge where the levels of both the old and the new source clock were 0 in the preceding cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | always-running controller clock |
| rstN | input | 1 | active-low reset |
| cfgWe | input | 1 | control word write strobe (taken in run only) |
| cfgMode | input | 2 | standby mode: 00 idle, 01 stop, 10 watch, 11 sub-watch |
| cfgOscOff | input | 1 | main oscillator stop bit |
| cfgSubSel | input | 1 | slow clock choice: 0 ring oscillator, 1 sub oscillator |
| cfgCalSel | input | 1 | calibration timer clock: 0 peripheral, 1 main oscillator |
| cfgMainReq | input | 1 | request the CPU to run on the main oscillator |
| cfgWakeMask | input | WAKE_N | wake event enables |
| standbyReq | input | 1 | enter the configured standby mode |
| wakeReq | input | WAKE_N | wake events |
| mainClkLvl | input | 1 | sampled main oscillator level |
| subClkLvl | input | 1 | sampled sub oscillator level |
| ringClkLvl | input | 1 | sampled ring oscillator level |
| mainOscEn | output | 1 | main oscillator enable |
| oscStable | output | 1 | main oscillator start-up count elapsed |
| cpuSrc | output | 2 | CPU clock source: 0 ring, 1 sub, 2 main |
| cpuClkEn | output | 1 | CPU clock gate |
| periClkEn | output | 1 | peripheral clock gate |
| wtClkEn | output | 1 | main-oscillator clock gate to watch timer and display driver |
| calClkSel | output | 1 | calibration timer clock select |
| pwrState | output | 3 | 0 run, 1 idle, 2 stop, 3 watch, 4 sub-watch, 5 start-up wait |

## Verification
A wrong standby-state choice shows on pwrState at the edge after the standby request, and on the clock gates in the same cycle. A start-up counter that reloads or counts wrongly moves the rise of oscStable off its exact edge. It also delays or advances the switch of cpuSrc to the main oscillator by the same number of cycles. A source selector that ignores the clock levels shows as a cpuSrc change while a held-high level is applied. A lost oscillator-stop value shows after wake-up as the wrong final cpuSrc, or as mainOscEn left on in sub-watch.

// File: rtl/pscPkg.sv
package pscPkg;

  typedef enum logic [2:0] {
    ST_RUN      = 3'd0,
    ST_IDLE     = 3'd1,
    ST_STOP     = 3'd2,
    ST_WATCH    = 3'd3,
    ST_SUBWATCH = 3'd4,
    ST_WAKEWAIT = 3'd5
  } pwrState_e;

  typedef enum logic [1:0] {
    SRC_RING = 2'd0,
    SRC_SUB  = 2'd1,
    SRC_MAIN = 2'd2
  } clkSrc_e;

  localparam logic [1:0] MODE_IDLE  = 2'b00;
  localparam logic [1:0] MODE_STOP  = 2'b01;
  localparam logic [1:0] MODE_WATCH = 2'b10;
  localparam logic [1:0] MODE_SUBW  = 2'b11;

  typedef struct packed {
    logic    oscEn;
    clkSrc_e srcReq;
    logic    cpuGate;
    logic    periGate;
    logic    wtGate;
  } pscStrb_t;

endpackage

// File: rtl/pscCtrl.sv
module pscCtrl
  import pscPkg::*;
#(
  parameter int WAKE_N = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWe,
  input  logic [1:0]        cfgMode,
  input  logic              cfgOscOff,
  input  logic              cfgSubSel,
  input  logic              cfgCalSel,
  input  logic              cfgMainReq,
  input  logic [WAKE_N-1:0] cfgWakeMask,
  input  logic              standbyReq,
  input  logic [WAKE_N-1:0] wakeReq,
  input  logic              oscStable,
  output pscStrb_t          strb,
  output logic              calClkSel,
  output pwrState_e         state
);

  logic [1:0]        modeSel;
  logic              oscOff;
  logic              subSel;
  logic              calSel;
  logic              wantMain;
  logic [WAKE_N-1:0] wakeMask;
  logic              wakeHit;
  pwrState_e         entryState;

  assign wakeHit   = |(wakeReq & wakeMask);
  assign calClkSel = calSel;

  // standby state actually entered: slow-clock operation forbids idle and watch
  always_comb begin
    unique case (modeSel)
      MODE_IDLE:  entryState = wantMain ? ST_IDLE : ST_SUBWATCH;
      MODE_STOP:  entryState = ST_STOP;
      MODE_WATCH: entryState = wantMain ? ST_WATCH : ST_SUBWATCH;
      default:    entryState = ST_SUBWATCH;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_RUN;
      modeSel  <= MODE_IDLE;
      oscOff   <= 1'b1;
      subSel   <= 1'b0;
      calSel   <= 1'b0;
      wantMain <= 1'b0;
      wakeMask <= '1;
    end else begin
      unique case (state)
        ST_RUN: begin
          if (cfgWe) begin
            modeSel  <= cfgMode;
            oscOff   <= cfgOscOff;
            subSel   <= cfgSubSel;
            calSel   <= cfgCalSel;
            wakeMask <= cfgWakeMask;
            wantMain <= cfgMainReq & oscStable;
          end
          if (standbyReq) state <= entryState;
        end
        ST_IDLE: if (wakeHit) state <= ST_RUN;
        ST_STOP: if (wakeHit) state <= wantMain ? ST_WAKEWAIT : ST_RUN;
        ST_WATCH: if (wakeHit) begin
          oscOff <= 1'b0;
          state  <= ST_WAKEWAIT;
        end
        ST_SUBWATCH: if (wakeHit) begin
          if (!oscOff) begin
            state <= ST_WAKEWAIT;
          end else begin
            state    <= ST_RUN;
            wantMain <= 1'b0;
          end
        end
        ST_WAKEWAIT: if (oscStable) begin
          state    <= ST_RUN;
          wantMain <= 1'b1;
        end
        default: state <= ST_RUN;
      endcase
    end
  end

  // strobes to the datapath
  always_comb begin
    unique case (state)
      ST_RUN:      strb.oscEn = ~oscOff | wantMain;
      ST_IDLE:     strb.oscEn = ~oscOff | wantMain;
      ST_WATCH:    strb.oscEn = ~oscOff;
      ST_WAKEWAIT: strb.oscEn = 1'b1;
      default:     strb.oscEn = 1'b0;
    endcase
    strb.srcReq   = (wantMain && oscStable) ? SRC_MAIN : (subSel ? SRC_SUB : SRC_RING);
    strb.cpuGate  = (state == ST_RUN) || (state == ST_WAKEWAIT);
    strb.periGate = (state == ST_RUN) || (state == ST_IDLE) || (state == ST_WAKEWAIT);
    strb.wtGate   = ~oscOff & strb.oscEn;
  end

endmodule

// File: rtl/pscDatapath.sv
module pscDatapath
  import pscPkg::*;
#(
  parameter int STAB_CYCLES = 16
) (
  input  logic     clk,
  input  logic     rstN,
  input  pscStrb_t strb,
  input  logic     mainClkLvl,
  input  logic     subClkLvl,
  input  logic     ringClkLvl,
  output logic     mainOscEn,
  output logic     oscStable,
  output clkSrc_e  cpuSrc,
  output logic     cpuClkEn,
  output logic     periClkEn,
  output logic     wtClkEn
);

  localparam int CNT_W = $clog2(STAB_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(STAB_CYCLES);
  localparam int N_SRC = 4;

  logic [CNT_W-1:0] stabCnt;
  logic [N_SRC-1:0] srcLvl;
  logic             oldLow;
  logic             newLow;

  // start-up counter: reloads while the oscillator is off
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                stabCnt <= CNT_LOAD;
    else if (!strb.oscEn)     stabCnt <= CNT_LOAD;
    else if (stabCnt != '0)   stabCnt <= stabCnt - 1'b1;
  end

  assign oscStable = strb.oscEn && (stabCnt == '0);
  assign mainOscEn = strb.oscEn;

  // per-source clock level, indexed by source code
  generate
    for (genvar i = 0; i < N_SRC; i++) begin : g_lvl
      if (i == int'(SRC_RING))      begin : g_r assign srcLvl[i] = ringClkLvl; end
      else if (i == int'(SRC_SUB))  begin : g_s assign srcLvl[i] = subClkLvl;  end
      else if (i == int'(SRC_MAIN)) begin : g_m assign srcLvl[i] = mainClkLvl; end
      else                          begin : g_z assign srcLvl[i] = 1'b0;       end
    end
  endgenerate

  assign oldLow = ~srcLvl[cpuSrc];
  assign newLow = ~srcLvl[strb.srcReq];

  // source changes only while both clocks are low
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      cpuSrc <= SRC_RING;
    else if ((strb.srcReq != cpuSrc) && oldLow && newLow)
      cpuSrc <= strb.srcReq;
  end

  assign cpuClkEn  = strb.cpuGate;
  assign periClkEn = strb.periGate;
  assign wtClkEn   = strb.wtGate;

endmodule

// File: rtl/pscTop.sv
module pscTop
  import pscPkg::*;
#(
  parameter int STAB_CYCLES = 16,
  parameter int WAKE_N      = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWe,
  input  logic [1:0]        cfgMode,
  input  logic              cfgOscOff,
  input  logic              cfgSubSel,
  input  logic              cfgCalSel,
  input  logic              cfgMainReq,
  input  logic [WAKE_N-1:0] cfgWakeMask,
  input  logic              standbyReq,
  input  logic [WAKE_N-1:0] wakeReq,
  input  logic              mainClkLvl,
  input  logic              subClkLvl,
  input  logic              ringClkLvl,
  output logic              mainOscEn,
  output logic              oscStable,
  output logic [1:0]        cpuSrc,
  output logic              cpuClkEn,
  output logic              periClkEn,
  output logic              wtClkEn,
  output logic              calClkSel,
  output logic [2:0]        pwrState
);

  pscStrb_t  strb;
  pwrState_e stateQ;
  clkSrc_e   srcQ;

  pscCtrl #(.WAKE_N(WAKE_N)) u_ctrl (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgMode(cfgMode),
    .cfgOscOff(cfgOscOff), .cfgSubSel(cfgSubSel), .cfgCalSel(cfgCalSel),
    .cfgMainReq(cfgMainReq), .cfgWakeMask(cfgWakeMask),
    .standbyReq(standbyReq), .wakeReq(wakeReq), .oscStable(oscStable),
    .strb(strb), .calClkSel(calClkSel), .state(stateQ)
  );

  pscDatapath #(.STAB_CYCLES(STAB_CYCLES)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb),
    .mainClkLvl(mainClkLvl), .subClkLvl(subClkLvl), .ringClkLvl(ringClkLvl),
    .mainOscEn(mainOscEn), .oscStable(oscStable), .cpuSrc(srcQ),
    .cpuClkEn(cpuClkEn), .periClkEn(periClkEn), .wtClkEn(wtClkEn)
  );

  assign cpuSrc   = srcQ;
  assign pwrState = stateQ;

endmodule

// File: rtl/pscChk.sv
module pscChk (
  input logic       clk,
  input logic       rstN,
  input logic [2:0] pwrState,
  input logic [1:0] cpuSrc,
  input logic       mainOscEn,
  input logic       oscStable,
  input logic       cpuClkEn,
  input logic       periClkEn,
  input logic       mainClkLvl,
  input logic       subClkLvl,
  input logic       ringClkLvl
);

  function automatic logic lvlOf(input logic [1:0] s, input logic m,
                                 input logic sb, input logic r);
    case (s)
      2'd0:    return r;
      2'd1:    return sb;
      2'd2:    return m;
      default: return 1'b0;
    endcase
  endfunction

  // R4
  subwatch_osc_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pwrState == 3'd4) |-> !mainOscEn);

  // R5
  wakewait_osc_on_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pwrState == 3'd5) |-> mainOscEn);

  // R9
  main_needs_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cpuSrc == 2'd2 && $past(cpuSrc) != 2'd2) |-> $past(oscStable));

  // R12
  stop_gates_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pwrState == 3'd2) |-> (!cpuClkEn && !periClkEn));

  // R12
  idle_gates_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pwrState == 3'd1) |-> (!cpuClkEn && periClkEn));

  // R14
  glitch_free_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cpuSrc != $past(cpuSrc)) |->
      (!lvlOf($past(cpuSrc), $past(mainClkLvl), $past(subClkLvl), $past(ringClkLvl)) &&
       !lvlOf(cpuSrc, $past(mainClkLvl), $past(subClkLvl), $past(ringClkLvl))));

endmodule

bind pscTop pscChk u_chk (
  .clk(clk), .rstN(rstN), .pwrState(pwrState), .cpuSrc(cpuSrc),
  .mainOscEn(mainOscEn), .oscStable(oscStable), .cpuClkEn(cpuClkEn),
  .periClkEn(periClkEn), .mainClkLvl(mainClkLvl), .subClkLvl(subClkLvl),
  .ringClkLvl(ringClkLvl)
);

// File: tb/pscTop_tb.sv
module pscTop_tb;

  localparam int CLK_PERIOD = 10;
  localparam int STAB = 16;
  localparam int WN = 4;

  // {onMain, mode[1:0], expected pwrState[2:0]}  (R2, R3)
  localparam logic [5:0] VEC [8] = '{
    {1'b1, 2'b00, 3'd1}, {1'b1, 2'b01, 3'd2}, {1'b1, 2'b10, 3'd3}, {1'b1, 2'b11, 3'd4},
    {1'b0, 2'b00, 3'd4}, {1'b0, 2'b01, 3'd2}, {1'b0, 2'b10, 3'd4}, {1'b0, 2'b11, 3'd4}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cfgWe = 0, cfgOscOff = 0, cfgSubSel = 0, cfgCalSel = 0, cfgMainReq = 0;
  logic [1:0] cfgMode = 0;
  logic [WN-1:0] cfgWakeMask = '1, wakeReq = '0;
  logic standbyReq = 0, mainClkLvl = 0, subClkLvl = 0, ringClkLvl = 0;
  logic mainOscEn, oscStable, cpuClkEn, periClkEn, wtClkEn, calClkSel;
  logic [1:0] cpuSrc;
  logic [2:0] pwrState;

  int nChk = 0;
  int nFail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pscTop #(.STAB_CYCLES(STAB), .WAKE_N(WN)) u_dut (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgMode(cfgMode),
    .cfgOscOff(cfgOscOff), .cfgSubSel(cfgSubSel), .cfgCalSel(cfgCalSel),
    .cfgMainReq(cfgMainReq), .cfgWakeMask(cfgWakeMask), .standbyReq(standbyReq),
    .wakeReq(wakeReq), .mainClkLvl(mainClkLvl), .subClkLvl(subClkLvl),
    .ringClkLvl(ringClkLvl), .mainOscEn(mainOscEn), .oscStable(oscStable),
    .cpuSrc(cpuSrc), .cpuClkEn(cpuClkEn), .periClkEn(periClkEn),
    .wtClkEn(wtClkEn), .calClkSel(calClkSel), .pwrState(pwrState)
  );

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string req, input int act, input int exp);
    nChk++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic doReset();
    rstN = 1'b0;
    repeat (2) tick();
    rstN = 1'b1;
    tick();
  endtask

  task automatic writeCfg(input logic [1:0] m, input logic off, input logic sub,
                          input logic cal, input logic mreq, input logic [WN-1:0] mask);
    cfgMode = m; cfgOscOff = off; cfgSubSel = sub; cfgCalSel = cal;
    cfgMainReq = mreq; cfgWakeMask = mask; cfgWe = 1'b1;
    tick();
    cfgWe = 1'b0;
  endtask

  task automatic enterStandby();
    standbyReq = 1'b1;
    tick();
    standbyReq = 1'b0;
  endtask

  task automatic wake(input logic [WN-1:0] w);
    wakeReq = w;
    tick();
    wakeReq = '0;
  endtask

  // start the main oscillator, wait out its count, move the CPU onto it
  task automatic goMain(input logic [1:0] m);
    writeCfg(m, 1'b0, 1'b0, 1'b0, 1'b0, '1);
    repeat (STAB + 1) tick();
    writeCfg(m, 1'b0, 1'b0, 1'b0, 1'b1, '1);
    tick();
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    nFail++;
    $display("FAIL watchdog: actual 0 expected 1");
    $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
    $finish;
  end

  initial begin
    @(negedge clk);
    doReset();

    // R1 reset state
    chk("R1 pwrState", pwrState, 0);
    chk("R1 cpuSrc", cpuSrc, 0);
    chk("R1 mainOscEn", mainOscEn, 0);
    chk("R1 oscStable", oscStable, 0);
    chk("R1 wtClkEn", wtClkEn, 0);
    chk("R1 calClkSel", calClkSel, 0);
    chk("R1 cpuClkEn", cpuClkEn, 1);
    chk("R1 periClkEn", periClkEn, 1);

    // table walk: standby entry per mode and clock source
    foreach (VEC[i]) begin
      doReset();
      if (VEC[i][5]) begin
        goMain(VEC[i][4:3]);
        chk("R2 setup cpuSrc", cpuSrc, 2);
      end else begin
        writeCfg(VEC[i][4:3], 1'b0, 1'b0, 1'b0, 1'b0, '1);
      end
      enterStandby();
      chk(VEC[i][5] ? "R2 state" : "R3 state", pwrState, VEC[i][2:0]);
      if (VEC[i][2:0] == 3'd4) chk("R4 mainOscEn", mainOscEn, 0);
      if (VEC[i][2:0] == 3'd1) begin
        chk("R12 idle cpu", cpuClkEn, 0);
        chk("R12 idle peri", periClkEn, 1);
      end
      if (VEC[i][2:0] == 3'd2) begin
        chk("R12 stop cpu", cpuClkEn, 0);
        chk("R12 stop peri", periClkEn, 0);
      end
    end

    // R8 / R9: exact start-up count, early main request rejected
    doReset();
    writeCfg(2'b00, 1'b0, 1'b0, 1'b0, 1'b1, '1);
    chk("R8 mainOscEn", mainOscEn, 1);
    repeat (STAB - 1) tick();
    chk("R8 not yet stable", oscStable, 0);
    chk("R9 early request ignored", cpuSrc, 0);
    tick();
    chk("R8 stable", oscStable, 1);
    writeCfg(2'b00, 1'b0, 1'b0, 1'b0, 1'b1, '1);
    tick();
    chk("R9 on main", cpuSrc, 2);
    chk("R12 run cpu", cpuClkEn, 1);

    // R14: main level held high blocks the move to the sub oscillator
    mainClkLvl = 1'b1;
    writeCfg(2'b00, 1'b0, 1'b1, 1'b0, 1'b0, '1);
    repeat (3) tick();
    chk("R14 held", cpuSrc, 2);
    mainClkLvl = 1'b0;
    tick();
    chk("R14 switched", cpuSrc, 1);

    // R11
    writeCfg(2'b00, 1'b0, 1'b1, 1'b1, 1'b0, '1);
    chk("R11 calClkSel", calClkSel, 1);
    writeCfg(2'b00, 1'b0, 1'b1, 1'b0, 1'b0, '1);
    chk("R11 calClkSel back", calClkSel, 0);

    // R6: sub-watch wake with oscillator stop bit set
    doReset();
    writeCfg(2'b11, 1'b1, 1'b1, 1'b0, 1'b0, '1);
    enterStandby();
    chk("R6 in subwatch", pwrState, 4);
    wake(4'b0001);
    chk("R6 back to run", pwrState, 0);
    chk("R6 osc off", mainOscEn, 0);
    tick();
    chk("R6 on sub", cpuSrc, 1);

    // R5: sub-watch wake with oscillator stop bit clear
    doReset();
    writeCfg(2'b11, 1'b0, 1'b0, 1'b0, 1'b0, '1);
    enterStandby();
    chk("R4 osc off in subwatch", mainOscEn, 0);
    wake(4'b0001);
    chk("R5 wait state", pwrState, 5);
    chk("R5 osc on", mainOscEn, 1);
    repeat (STAB) tick();
    chk("R5 still waiting", pwrState, 5);
    chk("R5 still ring", cpuSrc, 0);
    tick();
    chk("R5 run", pwrState, 0);
    tick();
    chk("R5 on main", cpuSrc, 2);

    // R7 / R10: watch with oscillator kept, then stopped
    doReset();
    goMain(2'b10);
    writeCfg(2'b10, 1'b0, 1'b0, 1'b0, 1'b1, '1);
    enterStandby();
    chk("R7 watch", pwrState, 3);
    chk("R7 osc kept", mainOscEn, 1);
    wake(4'b0001);
    tick();
    chk("R7 run", pwrState, 0);
    chk("R7 main kept", cpuSrc, 2);
    chk("R10 wt on", wtClkEn, 1);
    writeCfg(2'b10, 1'b1, 1'b0, 1'b0, 1'b1, '1);
    chk("R10 wt off", wtClkEn, 0);
    chk("R10 osc still on", mainOscEn, 1);
    chk("R10 cpu on main", cpuSrc, 2);
    enterStandby();
    chk("R7 watch2", pwrState, 3);
    chk("R7 osc stopped", mainOscEn, 0);
    wake(4'b0001);
    chk("R7 wait", pwrState, 5);
    repeat (STAB + 1) tick();
    chk("R7 run2", pwrState, 0);
    tick();
    chk("R7 main after restart", cpuSrc, 2);

    // R13: masked wake ignored, enabled wake taken
    doReset();
    writeCfg(2'b01, 1'b1, 1'b0, 1'b0, 1'b0, 4'b0010);
    enterStandby();
    wake(4'b1101);
    tick();
    chk("R13 masked", pwrState, 2);
    wake(4'b0010);
    chk("R13 enabled", pwrState, 0);

    $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
    $finish;
  end

endmodule